// File: doc/BRIEF.md
# Work-Group Barrier Collection Queue

This block is a synchronization barrier for a pipelined datapath that carries many parallel work-items, grouped into work-groups. Each work-item arrives over a valid/ready handshake. It brings a payload, which is the full set of its live variables, and the ID of its work-group. The block stores every payload as one queue entry. It releases nothing until the number of arrivals from the group being collected equals the group size given on a configuration input. When that happens, the stored work-items leave in arrival order, one per output transfer.

Members of one work-group are expected to arrive back to back. The storage holds one maximum-size group (`DEPTH` entries). While a completed group drains, the input side keeps accepting the next group into the slots that have been freed. Those entries are counted separately and are not released with the draining group. A work-item whose ID differs from the group still being collected sets a sticky error flag. Only reset clears that flag.

Two state machines control the block. The collector FSM has the state GATH_IDLE, in which no group is open, and the state GATH_OPEN, in which a group is partly gathered. It moves from IDLE to OPEN on the first arrival when the size is greater than 1. It moves from OPEN to IDLE on the arrival that completes the group. When the size is 1 it stays in IDLE. The release FSM has the state DRN_HOLD, in which nothing is releasable, and the state DRN_BURST, in which released entries remain. It moves from HOLD to BURST when a group completes. It moves from BURST to HOLD when the last released entry is taken and no other group completes in the same cycle. The group size must lie between 1 and `DEPTH` and must be held stable while a group is open.

Top module: `wg_barrier_queue`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `out_valid` is 0, `in_ready` is 1 and `grp_err` is 0.
- R2: `out_valid` stays 0 while fewer than `cfg_group_size` work-items of the open group have been accepted.
- R3: In the cycle after the edge that accepts the last member of a group, `out_valid` is 1. The group's payloads then appear on `out_data` in the order they were accepted, one per cycle in which `out_valid` and `out_ready` are both high.
- R4: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values.
- R5: `in_ready` is 0 while `DEPTH` entries are stored, so no payload is accepted. It returns to 1 in the cycle after an output transfer.
- R6: Members of the next group are accepted while a completed group drains. They are not released until their own group is complete, and `out_valid` falls once the earlier group is gone.
- R7: An accepted work-item whose `in_wg` differs from the ID of the open group sets `grp_err` from the next cycle until reset. That work-item is still stored and counted toward the open group.
- R8: With `cfg_group_size` equal to 1, every accepted work-item is releasable in the next cycle. Consecutive items with different IDs do not set `grp_err`.
- R9: An output transfer and an input transfer in the same cycle are both honoured. This also holds when that input completes a group: the released count grows by the group size and drops by one for the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_group_size | input | $clog2(DEPTH+1) | Work-items per work-group, 1 to DEPTH |
| in_valid | input | 1 | Incoming work-item present |
| in_ready | output | 1 | Queue can take a work-item |
| in_data | input | DATA_W | Live-variable payload of the work-item |
| in_wg | input | WG_W | Work-group ID of the work-item |
| out_valid | output | 1 | A released work-item is presented |
| out_ready | input | 1 | Downstream takes the presented work-item |
| out_data | output | DATA_W | Payload of the presented work-item |
| grp_err | output | 1 | Sticky flag for a foreign work-group ID during collection |

## Verification
Two functions can coincide in one cycle: an output transfer from a draining group, and an input transfer that adds to, or completes, the next group. The vector table covers this with a group size of 3. It stalls the output for one cycle, then pops and accepts in the same cycle. Later, the third member of the next group arrives on the same edge that removes the last entry of the earlier group. The bench judges the result cycle by cycle from `out_valid` and `out_data`. Both groups must come out whole and in order, with no gap and no early release.

// File: rtl/wg_barrier_pkg.sv
package wg_barrier_pkg;

    typedef enum logic {
        GATH_IDLE = 1'b0,
        GATH_OPEN = 1'b1
    } gath_state_e;

    typedef enum logic {
        DRN_HOLD  = 1'b0,
        DRN_BURST = 1'b1
    } drn_state_e;

endpackage

// File: rtl/wg_slot_ring.sv
module wg_slot_ring #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              full,
    output logic [CNT_W-1:0]  occ
);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;

    function automatic logic [PTR_W-1:0] advance(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= advance(wr_ptr);
            if (pop)  rd_ptr <= advance(rd_ptr);
            unique case ({push, pop})
                2'b10:   occ <= occ + CNT_W'(1);
                2'b01:   occ <= occ - CNT_W'(1);
                default: occ <= occ;
            endcase
        end
    end

    assign rdata = slots[rd_ptr];
    assign full  = (occ == CNT_W'(DEPTH));

    // R5
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        full |-> !push);

    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        pop |-> (occ != '0));

endmodule

// File: rtl/wg_gather_fsm.sv
module wg_gather_fsm
    import wg_barrier_pkg::*;
#(
    parameter int WG_W  = 4,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [WG_W-1:0]  in_wg,
    input  logic [CNT_W-1:0] grp_size,
    output logic             grp_done,
    output logic             grp_err
);

    gath_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [WG_W-1:0]  wg_q, wg_d;
    logic             err_d, foreign;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GATH_IDLE;
            cnt_q   <= '0;
            wg_q    <= '0;
            grp_err <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            wg_q    <= wg_d;
            grp_err <= err_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        wg_d     = wg_q;
        grp_done = 1'b0;
        foreign  = 1'b0;
        unique case (state_q)
            GATH_IDLE: begin
                if (accept) begin
                    wg_d = in_wg;
                    if (grp_size == CNT_W'(1)) begin
                        grp_done = 1'b1;
                    end else begin
                        cnt_d   = CNT_W'(1);
                        state_d = GATH_OPEN;
                    end
                end
            end
            GATH_OPEN: begin
                if (accept) begin
                    foreign = (in_wg != wg_q);
                    if (cnt_q + CNT_W'(1) == grp_size) begin
                        grp_done = 1'b1;
                        cnt_d    = '0;
                        state_d  = GATH_IDLE;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            end
            default: state_d = GATH_IDLE;
        endcase
        err_d = grp_err | foreign;
    end

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        grp_err |=> grp_err);

    // R2
    open_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == GATH_OPEN) |-> (cnt_q != '0) && (cnt_q < grp_size));

endmodule

// File: rtl/wg_drain_fsm.sv
module wg_drain_fsm
    import wg_barrier_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grp_done,
    input  logic [CNT_W-1:0] grp_size,
    input  logic             out_ready,
    output logic             out_valid,
    output logic             pop
);

    drn_state_e       state_q, state_d;
    logic [CNT_W-1:0] rel_q, rel_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DRN_HOLD;
            rel_q   <= '0;
        end else begin
            state_q <= state_d;
            rel_q   <= rel_d;
        end
    end

    always_comb begin
        out_valid = (state_q == DRN_BURST);
        pop       = out_valid && out_ready;
        rel_d     = rel_q + (grp_done ? grp_size : '0) - (pop ? CNT_W'(1) : '0);
        state_d   = state_q;
        unique case (state_q)
            DRN_HOLD:  if (grp_done)        state_d = DRN_BURST;
            DRN_BURST: if (rel_d == '0)     state_d = DRN_HOLD;
            default:                        state_d = DRN_HOLD;
        endcase
    end

    // R4
    hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid);

    // R3
    burst_count_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == DRN_BURST) |-> (rel_q != '0));

endmodule

// File: rtl/wg_barrier_queue.sv
module wg_barrier_queue #(
    parameter int DATA_W = 16,
    parameter int WG_W   = 4,
    parameter int DEPTH  = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_group_size,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [WG_W-1:0]   in_wg,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              grp_err
);

    logic             accept, pop, full, grp_done;
    logic [CNT_W-1:0] occ;

    assign in_ready = !full;
    assign accept   = in_valid && in_ready;

    wg_slot_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
        .clk   (clk),
        .rst   (rst),
        .push  (accept),
        .pop   (pop),
        .wdata (in_data),
        .rdata (out_data),
        .full  (full),
        .occ   (occ)
    );

    wg_gather_fsm #(.WG_W(WG_W), .CNT_W(CNT_W)) u_gather (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .in_wg    (in_wg),
        .grp_size (cfg_group_size),
        .grp_done (grp_done),
        .grp_err  (grp_err)
    );

    wg_drain_fsm #(.CNT_W(CNT_W)) u_drain (
        .clk       (clk),
        .rst       (rst),
        .grp_done  (grp_done),
        .grp_size  (cfg_group_size),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .pop       (pop)
    );

    // R2
    release_backed_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (occ != '0));

    // R4
    hold_data_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> $stable(out_data));

    // R5
    ready_return_chk: assert property (@(posedge clk) disable iff (rst)
        (full && pop) |=> in_ready);

endmodule

// File: tb/tb_wg_barrier_queue.sv
`timescale 1ns/1ps
module tb_wg_barrier_queue;

    localparam int DATA_W = 16;
    localparam int WG_W   = 4;
    localparam int DEPTH  = 8;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst;
    logic [CNT_W-1:0]  cfg_group_size;
    logic              in_valid, in_ready, out_valid, out_ready, grp_err;
    logic [DATA_W-1:0] in_data, out_data;
    logic [WG_W-1:0]   in_wg;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    wg_barrier_queue #(.DATA_W(DATA_W), .WG_W(WG_W), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst(rst), .cfg_group_size(cfg_group_size),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_wg(in_wg),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .grp_err(grp_err)
    );

    // vector fields: iv | wg[4] | data[16] | ordy | exp_ov | exp_od[16] | exp_ir
    localparam int NV = 11;
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 4'h2, 16'hA001, 1'b1, 1'b0, 16'h0000, 1'b1},
        {1'b1, 4'h2, 16'hA002, 1'b1, 1'b0, 16'h0000, 1'b1},
        {1'b1, 4'h2, 16'hA003, 1'b1, 1'b0, 16'h0000, 1'b1},
        {1'b1, 4'h3, 16'hB001, 1'b0, 1'b1, 16'hA001, 1'b1},
        {1'b1, 4'h3, 16'hB002, 1'b1, 1'b1, 16'hA001, 1'b1},
        {1'b0, 4'h0, 16'h0000, 1'b1, 1'b1, 16'hA002, 1'b1},
        {1'b1, 4'h3, 16'hB003, 1'b1, 1'b1, 16'hA003, 1'b1},
        {1'b0, 4'h0, 16'h0000, 1'b1, 1'b1, 16'hB001, 1'b1},
        {1'b0, 4'h0, 16'h0000, 1'b1, 1'b1, 16'hB002, 1'b1},
        {1'b0, 4'h0, 16'h0000, 1'b1, 1'b1, 16'hB003, 1'b1},
        {1'b0, 4'h0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive(input logic iv, input logic [WG_W-1:0] wg,
                         input logic [DATA_W-1:0] d, input logic ordy);
        in_valid  = iv;
        in_wg     = wg;
        in_data   = d;
        out_ready = ordy;
    endtask

    task automatic do_reset(input int size);
        drive(1'b0, '0, '0, 1'b0);
        cfg_group_size = CNT_W'(size);
        rst = 1'b1;
        tick();
        tick();
        rst = 1'b0;
    endtask

    task automatic push(input logic [WG_W-1:0] wg, input logic [DATA_W-1:0] d);
        drive(1'b1, wg, d, 1'b0);
        tick();
        drive(1'b0, '0, '0, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset(3);
        // R1 reset state
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 in_ready", 32'(in_ready), 1);
        chk("R1 grp_err", 32'(grp_err), 0);

        // vector walk: R2 R3 R4 R6 R9 with group size 3
        for (int i = 0; i < NV; i++) begin
            logic [39:0] v;
            v = VEC[i];
            chk("R2/R3/R6/R9 out_valid", 32'(out_valid), 32'(v[17]));
            if (v[17]) chk("R3/R4/R9 out_data", 32'(out_data), 32'(v[16:1]));
            chk("R5 in_ready", 32'(in_ready), 32'(v[0]));
            drive(v[39], v[38:35], v[34:19], v[18]);
            tick();
        end

        // R5 full queue backpressure, group size DEPTH
        do_reset(DEPTH);
        for (int k = 0; k < DEPTH; k++) begin
            chk("R2 out_valid before full group", 32'(out_valid), 0);
            push(4'h5, 16'h5000 + 16'(k));
        end
        drive(1'b1, 4'h5, 16'h5FFF, 1'b0);
        chk("R5 in_ready when full", 32'(in_ready), 0);
        chk("R3 out_valid after full group", 32'(out_valid), 1);
        chk("R3 first out_data", 32'(out_data), 32'h5000);
        tick();
        chk("R5 in_ready still low", 32'(in_ready), 0);
        chk("R4 out_data held", 32'(out_data), 32'h5000);
        drive(1'b0, '0, '0, 1'b1);
        tick();
        chk("R5 in_ready after pop", 32'(in_ready), 1);
        for (int k = 1; k < DEPTH; k++) begin
            chk("R3 order out_data", 32'(out_data), 32'h5000 + 32'(k));
            tick();
        end
        drive(1'b0, '0, '0, 1'b0);
        chk("R5 rejected item not stored", 32'(out_valid), 0);

        // R6 next group collected during drain, not released early
        do_reset(4);
        for (int k = 0; k < 4; k++) push(4'h1, 16'h1100 + 16'(k));
        push(4'h2, 16'h2200);
        push(4'h2, 16'h2201);
        drive(1'b0, '0, '0, 1'b1);
        for (int k = 0; k < 4; k++) begin
            chk("R6 first group out_data", 32'(out_data), 32'h1100 + 32'(k));
            tick();
        end
        chk("R6 partial group held back", 32'(out_valid), 0);
        tick();
        chk("R6 partial group still held", 32'(out_valid), 0);
        push(4'h2, 16'h2202);
        chk("R6 three of four held", 32'(out_valid), 0);
        push(4'h2, 16'h2203);
        chk("R6 second group released", 32'(out_valid), 1);
        chk("R6 second group head", 32'(out_data), 32'h2200);

        // R7 foreign group ID
        do_reset(3);
        push(4'h1, 16'h0701);
        chk("R7 no error on matching item", 32'(grp_err), 0);
        push(4'h2, 16'h0702);
        chk("R7 error raised", 32'(grp_err), 1);
        chk("R7 foreign item counted, not complete", 32'(out_valid), 0);
        push(4'h1, 16'h0703);
        chk("R7 group completes with foreign item", 32'(out_valid), 1);
        drive(1'b0, '0, '0, 1'b1);
        for (int k = 1; k <= 3; k++) begin
            chk("R7 stored order", 32'(out_data), 32'h0700 + 32'(k));
            tick();
        end
        chk("R7 error sticky", 32'(grp_err), 1);
        do_reset(3);
        chk("R1 error cleared by reset", 32'(grp_err), 0);

        // R8 group size one
        do_reset(1);
        push(4'h7, 16'h7001);
        chk("R8 single released", 32'(out_valid), 1);
        chk("R8 single data", 32'(out_data), 32'h7001);
        push(4'h8, 16'h8001);
        chk("R8 no error across groups", 32'(grp_err), 0);
        drive(1'b0, '0, '0, 1'b1);
        tick();
        chk("R8 second item next", 32'(out_data), 32'h8001);
        tick();
        chk("R8 drained", 32'(out_valid), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule